// File: doc/BRIEF.md
# Two-Depth Reset Sequencer

This block turns a set of reset causes into two nested reset outputs. The deep reset (power-on class) comes from the supply coming up and from a low level on the external reset pin. The shallow reset (power-up-clear class) comes from four fault reports: a watchdog overflow, a bad watchdog key, a bad flash key and an instruction fetch from unimplemented address space. Every deep reset also drives the shallow one. The shallow reset therefore covers everything that must restart on any reset. The deep reset covers only state that has to survive a soft fault.

Each output stays asserted for a set number of cycles after its cause goes away. When the shallow reset finally ends, the block raises a one-cycle request to load the program counter from the reset vector word. A sticky cause register records what caused the reset. The block also holds a state register whose bits fall into two classes. Bits in the first class are cleared by either reset depth. Bits in the second class are cleared only by the deep reset, so they survive a soft fault. This register stands in for a processor status word, whose sleep-mode bits must drop on any reset.

Top module: `reset_depth_ctrl`

## Requirements
- R1: While `rst_n` (supply good, active low) is low, `por_o` and `puc_o` are 1, `vector_load` is 0, `state_reg` is 0 and `cause_flags` is 6'b000001. After release, `por_o` is still 1 for 4 clock edges (HOLD_CYCLES) and `puc_o` is still 1 for 8 clock edges.
- R2: The external pin `ext_rst_n` passes through a two-stage synchronizer. Once the pin is low ahead of edge k, `por_o` is 0 after edges k and k+1 and becomes 1 after edge k+2.
- R3: When the pin returns high ahead of edge m, `por_o` stays 1 through edge m+4 and is 0 after edge m+5.
- R4: Every deep reset asserts `puc_o` in the same cycle as `por_o`. `puc_o` then stays 1 for HOLD_CYCLES edges after `por_o` falls, so it is 0 only after edge m+9.
- R5: Each shallow cause (`wdt_ovf`, `wdt_key_err`, `flash_key_err`, `bad_fetch`), sampled high at edge k, sets `puc_o` after edge k and leaves `por_o` at 0.
- R6: `puc_o` stays 1 for HOLD_CYCLES edges after the last edge that sampled a cause. A cause that arrives during the hold restarts the count.
- R7: `vector_load` is 1 for exactly the one cycle after `puc_o` falls, and `vector_addr` always reads 16'hFFFE.
- R8: `cause_flags` uses these bits: bit0 supply, bit1 pin, bit2 watchdog overflow, bit3 watchdog key, bit4 flash key, bit5 bad fetch. A shallow cause ORs its bit in at the edge that samples it. A bit is never cleared without a deep reset.
- R9: A deep reset from the pin loads `cause_flags` with 6'b000010.
- R10: On a shallow reset, the `state_reg` bits set in PUC_CLR_MASK (default 8'h0F) read 0 one edge after `puc_o` rises. The other bits keep their value.
- R11: A deep reset clears every bit of `state_reg` one edge after `por_o` rises.
- R12: `wr_en` loads `wr_data` into `state_reg` when no reset is active. It is ignored while `puc_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Supply-good, active low, synchronous; low means power is coming up |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_ovf | input | 1 | Watchdog overflow |
| wdt_key_err | input | 1 | Wrong watchdog key written |
| flash_key_err | input | 1 | Wrong flash controller key written |
| bad_fetch | input | 1 | Fetch from unimplemented memory |
| wr_en | input | 1 | Write strobe for the state register |
| wr_data | input | REG_W | Write data for the state register |
| por_o | output | 1 | Deep (power-on) reset, active high |
| puc_o | output | 1 | Shallow (power-up clear) reset, active high |
| vector_load | output | 1 | One-cycle request to load the PC from the vector |
| vector_addr | output | 16 | Address of the reset vector word |
| cause_flags | output | 6 | Sticky reset-cause record |
| state_reg | output | REG_W | Two-class state register |

## Verification
The timing runs from when the input is driven. A shallow cause sets `puc_o` one edge after it is driven, and `puc_o` falls on the fifth edge, with `vector_load` high for that cycle only. A pin assertion shows on `por_o` after the third edge, and a pin release drops `por_o` after the sixth edge and `puc_o` after the tenth. The register effects appear one edge after the reset output rises. The bench drives inputs on falling edges, steps a counted number of rising edges, and samples on the next falling edge. It checks one cycle before and one cycle after each expected transition, so an off-by-one in the synchronizer or the hold counters shows up as a failure.

// File: rtl/rdc_pkg.sv
// Package: shared constants for the two-depth reset sequencer.
// Assumes the cause order below is also the bit order of the cause flags.
package rdc_pkg;
    localparam int NUM_CAUSES  = 6;
    localparam int NUM_SOFT    = 4;
    localparam int IDX_SUPPLY  = 0;
    localparam int IDX_PIN     = 1;
    localparam int IDX_WDT_OVF = 2;
    localparam int IDX_WDT_KEY = 3;
    localparam int IDX_FL_KEY  = 4;
    localparam int IDX_FETCH   = 5;
    localparam int SOFT_BASE   = IDX_WDT_OVF;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;
    typedef logic [NUM_SOFT-1:0]   soft_vec_t;
endpackage

// File: rtl/rdc_pin_sync.sv
// Module: multi-stage synchronizer for an asynchronous level input.
// Assumes the input is a slow level; resets every stage to RESET_VAL.
module rdc_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the input through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rdc_hold_stretch.sv
// Module: holds an active output for HOLD cycles after its request drops.
// Assumes HOLD >= 1. The output is a decode of the counter only, so it has
// no combinational path from the request.
module rdc_hold_stretch #(
    parameter int   HOLD            = 4,
    parameter logic ACTIVE_AT_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD);

    logic [CW-1:0] cnt;

    // Reload on a request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ACTIVE_AT_RESET ? FULL : '0;
        end else if (req) begin
            cnt <= FULL;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/rdc_cause_log.sv
// Module: sticky record of reset causes.
// Assumes a pin-driven deep reset restarts the record and soft causes
// only add bits. The supply bit is set by the synchronous reset.
module rdc_cause_log
    import rdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_req,
    input  soft_vec_t  soft_req,
    output cause_vec_t flags
);
    cause_vec_t soft_bits;

    // Place the soft causes at their bit positions.
    always_comb begin
        soft_bits = '0;
        for (int i = 0; i < NUM_SOFT; i++) begin
            soft_bits[SOFT_BASE + i] = soft_req[i];
        end
    end

    // Restart on a deep reset, otherwise accumulate soft causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= cause_vec_t'(1) << IDX_SUPPLY;
        end else if (pin_req) begin
            flags <= cause_vec_t'(1) << IDX_PIN;
        end else begin
            flags <= flags | soft_bits;
        end
    end
endmodule

// File: rtl/rdc_class_reg.sv
// Module: register with two bit classes. Bits set in CLR_MASK clear on
// either reset depth, and the rest clear only on the deep reset.
// Assumes the writes come from logic that is itself held in reset.
module rdc_class_reg #(
    parameter int             W        = 8,
    parameter logic [W-1:0]   CLR_MASK = 8'h0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deep,
    input  logic         shallow,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    // Apply the reset class of each bit, otherwise take the write.
    always_ff @(posedge clk) begin
        if (!rst_n || deep) begin
            q <= '0;
        end else if (shallow) begin
            q <= q & ~CLR_MASK;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end
endmodule

// File: rtl/reset_depth_ctrl.sv
// Module: two-depth reset sequencer (top).
// rst_n is the supply-good level and acts as the synchronous reset.
// ext_rst_n is asynchronous and is synchronized here. The soft fault
// inputs are synchronous to clk.
module reset_depth_ctrl
    import rdc_pkg::*;
#(
    parameter int              HOLD_CYCLES  = 4,
    parameter int              SYNC_STAGES  = 2,
    parameter int              REG_W        = 8,
    parameter logic [REG_W-1:0] PUC_CLR_MASK = 8'h0F,
    parameter logic [15:0]     VECTOR_ADDR  = 16'hFFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_n,
    input  logic             wdt_ovf,
    input  logic             wdt_key_err,
    input  logic             flash_key_err,
    input  logic             bad_fetch,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             por_o,
    output logic             puc_o,
    output logic             vector_load,
    output logic [15:0]      vector_addr,
    output logic [5:0]       cause_flags,
    output logic [REG_W-1:0] state_reg
);
    logic      pin_sync_n;
    logic      por_req;
    logic      puc_any;
    logic      puc_req;
    logic      puc_prev;
    soft_vec_t soft_req;
    cause_vec_t flags_w;

    // Collect the soft causes in flag-bit order.
    assign soft_req = {bad_fetch, flash_key_err, wdt_key_err, wdt_ovf};
    assign puc_any  = |soft_req;

    rdc_pin_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_rst_n),
        .sync_out (pin_sync_n)
    );

    assign por_req = ~pin_sync_n;

    rdc_hold_stretch #(
        .HOLD            (HOLD_CYCLES),
        .ACTIVE_AT_RESET (1'b1)
    ) u_por_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (por_req),
        .active (por_o)
    );

    // A deep reset, requested or held, always requests the shallow one.
    assign puc_req = puc_any | por_req | por_o;

    rdc_hold_stretch #(
        .HOLD            (HOLD_CYCLES),
        .ACTIVE_AT_RESET (1'b1)
    ) u_puc_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (puc_req),
        .active (puc_o)
    );

    // Remember last cycle's shallow reset to find its trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            puc_prev <= 1'b1;
        end else begin
            puc_prev <= puc_o;
        end
    end

    assign vector_load = puc_prev & ~puc_o;
    assign vector_addr = VECTOR_ADDR;

    rdc_cause_log u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_req  (por_req),
        .soft_req (soft_req),
        .flags    (flags_w)
    );

    assign cause_flags = flags_w;

    rdc_class_reg #(
        .W        (REG_W),
        .CLR_MASK (PUC_CLR_MASK)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .deep    (por_o),
        .shallow (puc_o),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (state_reg)
    );
endmodule

// File: rtl/reset_depth_ctrl_chk.sv
// Checker: timing and ordering properties of the reset sequencer,
// bound into every instance of the top module.
module reset_depth_ctrl_chk #(
    parameter int               HOLD_CYCLES  = 4,
    parameter int               REG_W        = 8,
    parameter logic [REG_W-1:0] PUC_CLR_MASK = 8'h0F
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_o,
    input logic             puc_o,
    input logic             vector_load,
    input logic             por_req,
    input logic             puc_any,
    input logic [5:0]       cause_flags,
    input logic [REG_W-1:0] state_reg
);
    logic [7:0] puc_idle;
    logic [7:0] por_idle;

    // Count the cycles since the last shallow and the last deep request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            puc_idle <= '0;
            por_idle <= '0;
        end else begin
            puc_idle <= (puc_any || por_req || por_o) ? 8'd0 :
                        (puc_idle == 8'hFF ? puc_idle : puc_idle + 8'd1);
            por_idle <= por_req ? 8'd0 :
                        (por_idle == 8'hFF ? por_idle : por_idle + 8'd1);
        end
    end

    assert_por_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_o) |-> por_idle >= 8'(HOLD_CYCLES));

    assert_por_implies_puc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        por_o |-> puc_o);

    assert_puc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(puc_o) |-> puc_idle >= 8'(HOLD_CYCLES));

    assert_vector_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vector_load |-> (!puc_o && $past(puc_o)));

    assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !por_req |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags)));

    assert_keep_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (puc_o && !por_o) |=> ((state_reg & ~PUC_CLR_MASK) == $past(state_reg & ~PUC_CLR_MASK)));

    assert_deep_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        por_o |=> (state_reg == '0));
endmodule

bind reset_depth_ctrl reset_depth_ctrl_chk #(
    .HOLD_CYCLES  (HOLD_CYCLES),
    .REG_W        (REG_W),
    .PUC_CLR_MASK (PUC_CLR_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_o       (por_o),
    .puc_o       (puc_o),
    .vector_load (vector_load),
    .por_req     (por_req),
    .puc_any     (puc_any),
    .cause_flags (cause_flags),
    .state_reg   (state_reg)
);

// File: tb/sim_reset_depth_ctrl.sv
// Bench: directed scenarios for the two-depth reset sequencer.
module sim_reset_depth_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_ovf = 1'b0;
    logic       wdt_key_err = 1'b0;
    logic       flash_key_err = 1'b0;
    logic       bad_fetch = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       por_o;
    logic       puc_o;
    logic       vector_load;
    logic [15:0] vector_addr;
    logic [5:0] cause_flags;
    logic [7:0] state_reg;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    reset_depth_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_rst_n     (ext_rst_n),
        .wdt_ovf       (wdt_ovf),
        .wdt_key_err   (wdt_key_err),
        .flash_key_err (flash_key_err),
        .bad_fetch     (bad_fetch),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .por_o         (por_o),
        .puc_o         (puc_o),
        .vector_load   (vector_load),
        .vector_addr   (vector_addr),
        .cause_flags   (cause_flags),
        .state_reg     (state_reg)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One rising edge, then settle at the following falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_soft(input int idx, input logic v);
        case (idx)
            0: wdt_ovf = v;
            1: wdt_key_err = v;
            2: flash_key_err = v;
            default: bad_fetch = v;
        endcase
    endtask

    task automatic t_powerup();
        step(3);
        check("R1", "por in reset", por_o, 1);
        check("R1", "puc in reset", puc_o, 1);
        check("R1", "vload in reset", vector_load, 0);
        check("R1", "state in reset", state_reg, 0);
        check("R1", "flags in reset", cause_flags, 6'b000001);
        rst_n = 1'b1;
        step(3);
        check("R1", "por held", por_o, 1);
        step(1);
        check("R1", "por released", por_o, 0);
        step(3);
        check("R1", "puc held", puc_o, 1);
        step(1);
        check("R1", "puc released", puc_o, 0);
        check("R7", "vload after powerup", vector_load, 1);
        check("R7", "vector addr", vector_addr, 16'hFFFE);
        step(1);
        check("R7", "vload one cycle", vector_load, 0);
    endtask

    task automatic t_soft_causes();
        logic [5:0] exp_flags = 6'b000001;
        for (int c = 0; c < 4; c++) begin
            set_soft(c, 1'b1);
            step(1);
            set_soft(c, 1'b0);
            exp_flags[2 + c] = 1'b1;
            check("R5", "puc on soft cause", puc_o, 1);
            check("R5", "no por on soft cause", por_o, 0);
            check("R8", "flag bit set", cause_flags, exp_flags);
            step(3);
            check("R6", "puc held", puc_o, 1);
            step(1);
            check("R6", "puc released", puc_o, 0);
            check("R7", "vload after soft", vector_load, 1);
            step(1);
            check("R7", "vload drop", vector_load, 0);
        end
        check("R8", "flags accumulated", cause_flags, 6'h3D);
    endtask

    task automatic t_retrigger();
        wdt_ovf = 1'b1;
        step(1);
        wdt_ovf = 1'b0;
        step(2);
        bad_fetch = 1'b1;
        step(1);
        bad_fetch = 1'b0;
        step(3);
        check("R6", "retrigger extends hold", puc_o, 1);
        check("R7", "no early vload", vector_load, 0);
        step(1);
        check("R6", "retrigger release", puc_o, 0);
    endtask

    task automatic t_class_reg();
        wr_en = 1'b1; wr_data = 8'hA5;
        step(1);
        wr_en = 1'b0;
        check("R12", "write while idle", state_reg, 8'hA5);
        flash_key_err = 1'b1;
        step(1);
        flash_key_err = 1'b0;
        step(1);
        check("R10", "masked bits cleared", state_reg, 8'hA0);
        wr_en = 1'b1; wr_data = 8'hFF;
        step(1);
        wr_en = 1'b0;
        check("R12", "write ignored in puc", state_reg, 8'hA0);
        step(4);
        check("R10", "kept bits after puc", state_reg, 8'hA0);
    endtask

    task automatic t_pin_por();
        ext_rst_n = 1'b0;
        step(2);
        check("R2", "por not yet", por_o, 0);
        step(1);
        check("R2", "por asserted", por_o, 1);
        check("R4", "puc with por", puc_o, 1);
        check("R9", "flags on pin", cause_flags, 6'b000010);
        step(1);
        check("R11", "state cleared", state_reg, 0);
        step(2);
        ext_rst_n = 1'b1;
        step(5);
        check("R3", "por held after release", por_o, 1);
        step(1);
        check("R3", "por released", por_o, 0);
        check("R4", "puc outlasts por", puc_o, 1);
        step(3);
        check("R4", "puc still held", puc_o, 1);
        step(1);
        check("R4", "puc released", puc_o, 0);
        check("R7", "vload after pin", vector_load, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_powerup();
        step(2);
        t_soft_causes();
        step(2);
        t_retrigger();
        step(2);
        t_class_reg();
        step(2);
        t_pin_por();
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule